// File: doc/BRIEF.md
# Block Cipher Register Front-End

This block is the software-facing shell around a 128-bit block cipher engine. Software reaches it through a simple word-wide register bus. It holds a 256-bit key loaded through a window of eight word registers. It gathers four data words, written one after another to a single FIFO port, into one 128-bit block. It chooses the key length and the operation, and starts the engine either by command or automatically once the fourth data word is written. The cipher rounds are not part of this block. They sit behind a start/busy/done port that receives the block, the selected key bits, the key size and the operation code.

When the engine reports completion, the front-end captures the 128-bit result and raises a done flag. Software then drains the result one word at a time through the same FIFO port. A status register shows the fill state of both sides and whether the engine is busy. An interrupt line combines the done flag with an enable bit. A third operation code asks the engine to decrypt with the key schedule it kept from the last explicit encrypt or decrypt. The front-end only forwards that choice.

Top module: `cipher_regfront`

## Requirements
- R1: After reset the control, flag and enable registers read 0, status reads 0x0A (output empty, input empty), a FIFO read returns 0, `irq` is low, and addresses with no register (including the write-only key window) read 0.
- R2: Byte offsets are 0x000 control, 0x004 status, 0x008 flags, 0x00C interrupt enable, 0x010 data FIFO, and 0x400 to 0x41C key words. Control bit 0 is enable, bits 7:6 are key size and bits 9:8 are operation type; these read back as written. Bit 3 (start), bit 4 (input flush) and bit 5 (output flush) act on the write and always read 0.
- R3: Once the enable bit has been written 1, it stays 1 after later writes of 0.
- R4: When the engine is idle, the first FIFO word written goes to bits 31:0 of `eng_data`, the second to 63:32, the third to 95:64 and the fourth to 127:96. The fourth write returns the input count to 0 and issues a one-cycle `eng_start`, using the stored key size and type.
- R5: A write to 0x400+4k loads bits 32k+31:32k of the 256-bit key. `eng_key` carries key bits 127:0 for key size 0, bits 191:0 for size 1 and all 256 bits for sizes 2 and 3. Bits outside the window are 0.
- R6: `eng_op` is 0 (encrypt) for type 0, 1 (decrypt) for type 1, and 2 (decrypt with the kept schedule) for types 2 and 3.
- R7: A control write with bit 3 set, while the engine is idle, issues `eng_start` with the block currently held and with the key size and type carried in that same write.
- R8: An `eng_done` pulse captures `eng_result`, sets flag bit 0 and fills the output to four words, so status reads output full (bit 4) and not output empty (bit 3).
- R9: While result words remain, each FIFO read returns the next one (bits 31:0 first, 127:96 last), removes it and clears flag bit 0. With no words left a FIFO read returns 0.
- R10: `irq` is flag bit 0 AND interrupt-enable bit 0. Writing 1 to flag bit 0 clears it.
- R11: Control bit 4 empties the input count and bit 5 empties the output. A flush takes effect before a start carried in the same write.
- R12: Status bit 0 follows `eng_busy`. While it is high, FIFO writes and start commands are ignored. Status bit 1 is input empty, and bit 2 (input full) reads 0 because the input count wraps after the fourth word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the FIFO) |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Read data for the current address |
| irq | output | 1 | Done interrupt |
| eng_start | output | 1 | One-cycle engine launch |
| eng_op | output | 2 | Operation code for the engine |
| eng_key_size | output | 2 | Key size code latched at launch |
| eng_key | output | WORD_W*KEY_WORDS | Selected key bits, right-aligned |
| eng_data | output | WORD_W*BLK_WORDS | Assembled input block |
| eng_busy | input | 1 | Engine working |
| eng_done | input | 1 | Engine result valid pulse |
| eng_result | input | WORD_W*BLK_WORDS | Engine output block |

## Verification
Random rounds load a fresh random key and pick a random key size, type and interrupt enable. Each round writes four random data words and then drains the four result words. The check of the data bus shows whether the word order is reversed. The key check shows whether the right window is sliced. The operation check shows how types 2 and 3 fold together. Directed cases cover the start command with no FIFO traffic, starts and writes issued while busy, flushes partway through a fill and a drain, and the interaction of the done flag's write-one-to-clear with the interrupt enable.

// File: rtl/crf_pkg.sv
package crf_pkg;
   localparam int unsigned OFS_CTRL = 'h000;
   localparam int unsigned OFS_STAT = 'h004;
   localparam int unsigned OFS_FLAG = 'h008;
   localparam int unsigned OFS_IEN  = 'h00C;
   localparam int unsigned OFS_FIFO = 'h010;
   localparam int unsigned OFS_KEY  = 'h400;

   localparam int CB_EN     = 0;
   localparam int CB_START  = 3;
   localparam int CB_IFLUSH = 4;
   localparam int CB_OFLUSH = 5;
   localparam int CB_KSZ    = 6;
   localparam int CB_TYPE   = 8;

   typedef enum logic [1:0] {
      OP_ENC      = 2'd0,
      OP_DEC      = 2'd1,
      OP_DEC_KEPT = 2'd2
   } op_e;

   function automatic op_e type_to_op(input logic [1:0] t);
      case (t)
         2'd0:    return OP_ENC;
         2'd1:    return OP_DEC;
         default: return OP_DEC_KEPT;
      endcase
   endfunction
endpackage

// File: rtl/crf_inbuf.sv
module crf_inbuf #(
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic                          flush,
   input  logic [WORD_W-1:0]             wdata,
   output logic [WORD_W*BLK_WORDS-1:0]   block,
   output logic                          empty,
   output logic                          last
);
   localparam int IDX_W = $clog2(BLK_WORDS);

   logic [IDX_W-1:0]  cnt_q;
   logic [WORD_W-1:0] word_q [BLK_WORDS];

   assign last  = (cnt_q == IDX_W'(BLK_WORDS - 1));
   assign empty = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (flush)   cnt_q <= '0;
      else if (push)    cnt_q <= last ? '0 : cnt_q + 1'b1;
   end

   // Word w of the block is filled by the (w+1)-th push.
   for (genvar w = 0; w < BLK_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                word_q[w] <= '0;
         else if (push && cnt_q == IDX_W'(w))       word_q[w] <= wdata;
      end
      assign block[w*WORD_W +: WORD_W] = word_q[w];
   end

   AST_IN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && !last) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
   AST_IN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && last) |=> empty); // R4
   AST_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R11
endmodule

// File: rtl/crf_keyreg.sv
module crf_keyreg #(
   parameter int WORD_W    = 32,
   parameter int KEY_WORDS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [$clog2(KEY_WORDS)-1:0]  widx,
   input  logic [WORD_W-1:0]             wdata,
   input  logic [$clog2(KEY_WORDS+1)-1:0] win_words,
   output logic [WORD_W*KEY_WORDS-1:0]   key_win
);
   localparam int KIDX_W = $clog2(KEY_WORDS);
   localparam int WIN_W  = $clog2(KEY_WORDS + 1);

   logic [WORD_W-1:0] key_q [KEY_WORDS];

   for (genvar k = 0; k < KEY_WORDS; k++) begin : g_kw
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          key_q[k] <= '0;
         else if (wr && widx == KIDX_W'(k))   key_q[k] <= wdata;
      end
      // Low words are always in the window; high words drop out for short keys.
      assign key_win[k*WORD_W +: WORD_W] = (WIN_W'(k) < win_words) ? key_q[k] : '0;
   end
endmodule

// File: rtl/crf_outbuf.sv
module crf_outbuf #(
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               load,
   input  logic [WORD_W*BLK_WORDS-1:0]        result,
   input  logic                               pop,
   input  logic                               flush,
   output logic [WORD_W-1:0]                  rd_word,
   output logic [$clog2(BLK_WORDS+1)-1:0]     cnt
);
   localparam int CNT_W = $clog2(BLK_WORDS + 1);
   localparam int BLK_W = WORD_W * BLK_WORDS;

   logic [CNT_W-1:0] cnt_q;
   logic [BLK_W-1:0] res_q;

   assign cnt = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         res_q <= '0;
      end else if (load) begin
         cnt_q <= CNT_W'(BLK_WORDS);
         res_q <= result;
      end else if (flush) begin
         cnt_q <= '0;
      end else if (pop && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // With c words left, word BLK_WORDS-c is next; empty reads as zero.
   always_comb begin
      rd_word = '0;
      for (int i = 0; i < BLK_WORDS; i++)
         if (cnt_q == CNT_W'(BLK_WORDS - i)) rd_word = res_q[i*WORD_W +: WORD_W];
   end

   AST_OUT_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == CNT_W'(BLK_WORDS))); // R8
   AST_OUT_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && cnt_q != '0 && !load && !flush) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
   AST_OUT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BLK_WORDS)); // R8
endmodule

// File: rtl/cipher_regfront.sv
module cipher_regfront import crf_pkg::*; #(
   parameter int ADDR_W    = 12,
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int KEY_WORDS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [WORD_W-1:0]             wdata,
   output logic [WORD_W-1:0]             rdata,
   output logic                          irq,
   output logic                          eng_start,
   output logic [1:0]                    eng_op,
   output logic [1:0]                    eng_key_size,
   output logic [WORD_W*KEY_WORDS-1:0]   eng_key,
   output logic [WORD_W*BLK_WORDS-1:0]   eng_data,
   input  logic                          eng_busy,
   input  logic                          eng_done,
   input  logic [WORD_W*BLK_WORDS-1:0]   eng_result
);
   localparam int OCNT_W   = $clog2(BLK_WORDS + 1);
   localparam int KIDX_W   = $clog2(KEY_WORDS);
   localparam int WIN_W    = $clog2(KEY_WORDS + 1);
   localparam int KEY_SPAN = KEY_WORDS * (WORD_W / 8);

   if (WORD_W != 32) begin : g_bad_word
      $error("cipher_regfront: WORD_W must be 32");
   end
   if (BLK_WORDS < 2) begin : g_bad_blk
      $error("cipher_regfront: BLK_WORDS must be at least 2");
   end
   if (KEY_WORDS % 4 != 0) begin : g_bad_key
      $error("cipher_regfront: KEY_WORDS must be a multiple of 4");
   end
   if (ADDR_W < 11) begin : g_bad_addr
      $error("cipher_regfront: ADDR_W too small for the key window");
   end

   // Address decode
   logic hit_ctrl, hit_stat, hit_flag, hit_ien, hit_fifo, hit_key;
   assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
   assign hit_stat = (addr == ADDR_W'(OFS_STAT));
   assign hit_flag = (addr == ADDR_W'(OFS_FLAG));
   assign hit_ien  = (addr == ADDR_W'(OFS_IEN));
   assign hit_fifo = (addr == ADDR_W'(OFS_FIFO));
   assign hit_key  = (addr >= ADDR_W'(OFS_KEY)) && (addr < ADDR_W'(OFS_KEY + KEY_SPAN))
                     && (addr[1:0] == 2'b00);

   // Stored control fields
   logic       en_q;
   logic [1:0] ksz_q, type_q;
   logic       done_q, ie_q;
   logic       go_q;
   op_e        op_q;
   logic [1:0] lksz_q;

   logic in_empty, in_last;
   logic [OCNT_W-1:0] out_cnt;
   logic [WORD_W-1:0] out_word;

   logic ctrl_wr, cmd_start, fifo_push, auto_go, launch, pop_rd, flag_clr, ien_wr;
   logic [1:0] launch_type, launch_ksz;

   assign ctrl_wr     = wr_en && hit_ctrl;
   assign ien_wr      = wr_en && hit_ien;
   assign cmd_start   = ctrl_wr && wdata[CB_START];
   assign fifo_push   = wr_en && hit_fifo && !eng_busy;
   assign auto_go     = fifo_push && in_last;
   assign launch      = (cmd_start && !eng_busy) || auto_go;
   assign launch_type = cmd_start ? wdata[CB_TYPE +: 2] : type_q;
   assign launch_ksz  = cmd_start ? wdata[CB_KSZ +: 2]  : ksz_q;
   assign pop_rd      = rd_en && hit_fifo && (out_cnt != '0);
   assign flag_clr    = wr_en && hit_flag && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ksz_q  <= '0;
         type_q <= '0;
         ie_q   <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q   <= en_q | wdata[CB_EN];
            ksz_q  <= wdata[CB_KSZ +: 2];
            type_q <= wdata[CB_TYPE +: 2];
         end
         if (ien_wr) ie_q <= wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   done_q <= 1'b0;
      else if (eng_done)            done_q <= 1'b1;
      else if (pop_rd || flag_clr)  done_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q   <= 1'b0;
         op_q   <= OP_ENC;
         lksz_q <= '0;
      end else begin
         go_q <= launch;
         if (launch) begin
            op_q   <= type_to_op(launch_type);
            lksz_q <= launch_ksz;
         end
      end
   end

   // Number of key words in the window for the latched size code
   logic [WIN_W-1:0] win_words;
   always_comb begin
      case (lksz_q)
         2'd0:    win_words = WIN_W'(KEY_WORDS / 2);
         2'd1:    win_words = WIN_W'((KEY_WORDS * 3) / 4);
         default: win_words = WIN_W'(KEY_WORDS);
      endcase
   end

   crf_inbuf #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_inbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .flush (ctrl_wr && wdata[CB_IFLUSH]),
      .wdata (wdata),
      .block (eng_data),
      .empty (in_empty),
      .last  (in_last)
   );

   crf_keyreg #(.WORD_W(WORD_W), .KEY_WORDS(KEY_WORDS)) u_keyreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_en && hit_key),
      .widx      (addr[2 +: KIDX_W]),
      .wdata     (wdata),
      .win_words (win_words),
      .key_win   (eng_key)
   );

   crf_outbuf #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_outbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (eng_done),
      .result  (eng_result),
      .pop     (rd_en && hit_fifo),
      .flush   (ctrl_wr && wdata[CB_OFLUSH]),
      .rd_word (out_word),
      .cnt     (out_cnt)
   );

   assign eng_start    = go_q;
   assign eng_op       = op_q;
   assign eng_key_size = lksz_q;
   assign irq          = done_q & ie_q;

   always_comb begin
      rdata = '0;
      if (hit_ctrl) begin
         rdata[CB_EN]        = en_q;
         rdata[CB_KSZ +: 2]  = ksz_q;
         rdata[CB_TYPE +: 2] = type_q;
      end else if (hit_stat) begin
         rdata[0] = eng_busy;
         rdata[1] = in_empty;
         rdata[2] = 1'b0;           // input count wraps before it can read full
         rdata[3] = (out_cnt == '0);
         rdata[4] = (out_cnt == OCNT_W'(BLK_WORDS));
      end else if (hit_flag) begin
         rdata[0] = done_q;
      end else if (hit_ien) begin
         rdata[0] = ie_q;
      end else if (hit_fifo) begin
         rdata = out_word;
      end
   end

   AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q); // R3
   AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && eng_busy) |=> !eng_start); // R12
   AST_DONE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> (done_q && out_cnt == OCNT_W'(BLK_WORDS))); // R8
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(eng_done) || $past(ien_wr))); // R10
   AST_POP_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_rd && !eng_done) |=> !done_q); // R9
endmodule

// File: tb/cipher_regfront_test.sv
`timescale 1ns/1ps
module cipher_regfront_test;
   localparam int LAT = 4;
   localparam logic [11:0] A_CTRL = 12'h000, A_STAT = 12'h004, A_FLAG = 12'h008,
                           A_IEN = 12'h00C, A_FIFO = 12'h010, A_KEY = 12'h400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic         wr_en = 1'b0, rd_en = 1'b0;
   logic [11:0]  addr = '0;
   logic [31:0]  wdata = '0;
   wire  [31:0]  rdata;
   wire          irq, eng_start;
   wire  [1:0]   eng_op, eng_key_size;
   wire  [255:0] eng_key;
   wire  [127:0] eng_data;
   logic         eng_busy = 1'b0, eng_done = 1'b0;
   logic [127:0] eng_result = '0;

   int n_cmp = 0, n_bad = 0, n_starts = 0;
   int lat_cnt = 0;
   logic [127:0] cap_data = '0, model_out = '0;
   logic [255:0] cap_key = '0;
   logic [1:0]   cap_op = '0;

   cipher_regfront uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .eng_start(eng_start),
      .eng_op(eng_op), .eng_key_size(eng_key_size), .eng_key(eng_key),
      .eng_data(eng_data), .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_result(eng_result)
   );

   function automatic logic [127:0] crypt_fn(input logic [127:0] d, input logic [255:0] k,
                                             input logic [1:0] m);
      return d ^ k[127:0] ^ k[255:128] ^ {d[63:0], d[127:64]} ^ {64{m}};
   endfunction

   function automatic logic [255:0] win_fn(input logic [255:0] full, input logic [1:0] ksz);
      logic [255:0] r = '0;
      int n = (ksz == 2'd0) ? 4 : (ksz == 2'd1) ? 6 : 8;
      for (int i = 0; i < n; i++) r[i*32 +: 32] = full[i*32 +: 32];
      return r;
   endfunction

   function automatic logic [1:0] op_fn(input logic [1:0] t);
      return (t < 2'd2) ? t : 2'd2;
   endfunction

   // Engine model: busy for LAT cycles after a start, then a done pulse.
   always @(posedge clk) begin
      eng_done <= 1'b0;
      if (lat_cnt != 0) begin
         lat_cnt <= lat_cnt - 1;
         if (lat_cnt == 1) begin
            eng_busy   <= 1'b0;
            eng_done   <= 1'b1;
            eng_result <= model_out;
         end
      end else if (eng_start) begin
         eng_busy  <= 1'b1;
         lat_cnt   <= LAT;
         n_starts  <= n_starts + 1;
         cap_data  <= eng_data;
         cap_key   <= eng_key;
         cap_op    <= eng_op;
         model_out <= crypt_fn(eng_data, eng_key, eng_op);
      end
   end

   task automatic chk(input string req, input string what, input logic [255:0] act,
                      input logic [255:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0]  v;
      logic [255:0] keyfull;
      logic [127:0] blk, expres;
      int base;
      void'($urandom(32'h1C0FFEE5));
      keyfull = '0;
      blk = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(A_CTRL, v); chk("R1", "ctrl after reset", 256'(v), 256'h0);
      rd(A_STAT, v); chk("R1", "status after reset", 256'(v), 256'h0A);
      rd(A_FLAG, v); chk("R1", "flags after reset", 256'(v), 256'h0);
      rd(A_IEN, v);  chk("R1", "enable after reset", 256'(v), 256'h0);
      rd(A_FIFO, v); chk("R1", "fifo read after reset", 256'(v), 256'h0);
      rd(A_KEY, v);  chk("R1", "key window reads 0", 256'(v), 256'h0);
      chk("R1", "irq after reset", 256'(irq), 256'h0);

      // R2: field readback with self-clearing flush bits; R3 sticky enable
      wr(A_CTRL, 32'h0000_0271);
      rd(A_CTRL, v); chk("R2", "ctrl readback", 256'(v), 256'h241);
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v); chk("R3", "enable stays set", 256'(v), 256'h1);

      // Random rounds: R4 R5 R6 R8 R9 R10 R12
      for (int it = 0; it < 24; it++) begin
         logic [1:0] ksz, typ;
         logic       ie;
         ksz = 2'($urandom % 4);
         typ = 2'($urandom % 4);
         ie  = 1'($urandom % 2);
         for (int k = 0; k < 8; k++) begin
            keyfull[k*32 +: 32] = $urandom;
            wr(A_KEY + 12'(4 * k), keyfull[k*32 +: 32]);
         end
         wr(A_CTRL, 32'h1 | (32'(ksz) << 6) | (32'(typ) << 8));
         wr(A_IEN, 32'(ie));
         base = n_starts;
         for (int w = 0; w < 4; w++) begin
            blk[w*32 +: 32] = $urandom;
            wr(A_FIFO, blk[w*32 +: 32]);
            if (w == 0) begin
               rd(A_STAT, v); chk("R12", "status input not empty", 256'(v), 256'h08);
               chk("R4", "no start before fourth word", 256'(n_starts), 256'(base));
            end
         end
         idle(10);
         chk("R4", "one start after fourth word", 256'(n_starts), 256'(base + 1));
         chk("R4", "block word order", 256'(cap_data), 256'(blk));
         chk("R5", "key window", cap_key, win_fn(keyfull, ksz));
         chk("R6", "operation code", 256'(cap_op), 256'(op_fn(typ)));
         rd(A_STAT, v); chk("R8", "status after done", 256'(v), 256'h12);
         rd(A_FLAG, v); chk("R8", "done flag set", 256'(v), 256'h1);
         chk("R10", "irq follows enable", 256'(irq), 256'(ie));
         expres = crypt_fn(blk, win_fn(keyfull, ksz), op_fn(typ));
         for (int w = 0; w < 4; w++) begin
            rd(A_FIFO, v); chk("R9", "result word", 256'(v), 256'(expres[w*32 +: 32]));
            if (w == 0) begin
               rd(A_FLAG, v); chk("R9", "read clears done", 256'(v), 256'h0);
               chk("R10", "irq low after read", 256'(irq), 256'h0);
            end
         end
         rd(A_STAT, v); chk("R9", "status drained", 256'(v), 256'h0A);
         rd(A_FIFO, v); chk("R9", "empty fifo reads 0", 256'(v), 256'h0);
      end

      // R7: start command with key size 0, type 3, using the held block
      wr(A_IEN, 32'h0);
      base = n_starts;
      wr(A_CTRL, 32'h1 | 32'h8 | (32'd3 << 8));
      idle(10);
      chk("R7", "start command launches", 256'(n_starts), 256'(base + 1));
      chk("R7", "start uses held block", 256'(cap_data), 256'(blk));
      chk("R7", "start key size from write", 256'(cap_key), win_fn(keyfull, 2'd0));
      chk("R7", "start op from write", 256'(cap_op), 256'h2);

      // R11: output flush after a partial drain
      rd(A_FIFO, v);
      wr(A_CTRL, 32'h1 | 32'h20);
      rd(A_STAT, v); chk("R11", "output flushed", 256'(v), 256'h0A);
      rd(A_FIFO, v); chk("R11", "flushed fifo reads 0", 256'(v), 256'h0);

      // R12: busy reporting and ignored traffic
      base = n_starts;
      wr(A_CTRL, 32'h1 | 32'h8);
      idle(1);
      rd(A_STAT, v); chk("R12", "busy bit", 256'(v), 256'h0B);
      wr(A_FIFO, 32'hDEAD_BEEF);
      wr(A_CTRL, 32'h1 | 32'h8);
      idle(10);
      chk("R12", "start while busy ignored", 256'(n_starts), 256'(base + 1));
      rd(A_STAT, v); chk("R12", "fifo write while busy ignored", 256'(v), 256'h12);

      // R10: enable then write-one-to-clear
      wr(A_IEN, 32'h1);
      chk("R10", "irq with enable", 256'(irq), 256'h1);
      wr(A_FLAG, 32'h1);
      rd(A_FLAG, v); chk("R10", "flag cleared by write", 256'(v), 256'h0);
      chk("R10", "irq after clear", 256'(irq), 256'h0);

      // R11: input flush in the middle of a fill
      wr(A_CTRL, 32'h1 | 32'h20);
      wr(A_FIFO, 32'h1111_1111);
      wr(A_FIFO, 32'h2222_2222);
      rd(A_STAT, v); chk("R11", "partial fill", 256'(v), 256'h08);
      wr(A_CTRL, 32'h1 | 32'h10);
      rd(A_STAT, v); chk("R11", "input flushed", 256'(v), 256'h0A);
      base = n_starts;
      for (int w = 0; w < 4; w++) begin
         blk[w*32 +: 32] = 32'hA0A0_0000 + 32'(w);
         wr(A_FIFO, blk[w*32 +: 32]);
         if (w == 1) chk("R11", "no launch at old count", 256'(n_starts), 256'(base));
      end
      idle(10);
      chk("R11", "launch after refill", 256'(n_starts), 256'(base + 1));
      chk("R11", "refilled block", 256'(cap_data), 256'(blk));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule